// File: doc/BRIEF.md
# Two-Port GPIO with Flash Control and Serial Sensor Clocking

This block is a register-mapped pair of general-purpose ports, called port A and port D. Each port has an output-value register, an input-view register and a drive-enable register, held in a small word-indexed register window. Bus masters reach the window through a simple 32-bit request/response interface, and every request gets its response on the following cycle.

Port A controls an external NAND flash. Three bits of its output-value register drive the flash address-latch, command-latch and chip-enable pins. Bit 7 of its input view also shows the flash ready line.

Port D drives a bit-banged serial sensor. Any accepted write to its output-value register that flips bit 1 sends the sensor one clock edge event. The event carries the new clock level and a data bit. The sensor's serial output appears in bit 4 of the port D input view.

The input-view registers are not plain storage. A read of one returns the port's output value masked by its drive-enable, with the device status line ORed into one bit.

Top module: `sideband_gpio`

## Requirements
- R1: After reset, every register reads zero. The flash control pins are low, no event strobe is raised and no response is valid.
- R2: Each request gives rsp_valid in exactly the next cycle. A legal write to any plain register index (anything other than 0x01 and 0x11) stores the full word, and a read of that index returns it.
- R3: A read of port A's input view (index 0x01, byte 0x04) returns port A output value (index 0x00) AND port A drive-enable (index 0x02). A read of port D's input view (index 0x11, byte 0x44) returns index 0x10 AND index 0x12. Writes to the two input-view indices do not change what they read.
- R4: Bit 7 of the port A input view is ORed with nand_rdy. Bit 4 of the port D input view is ORed with sens_sdo. Both lines are sampled in the cycle of the request.
- R5: nand_ale follows bit 6 of the stored port A output value, nand_cle follows bit 5 and nand_ce follows bit 4. The pins change in the cycle after the write.
- R6: A legal write to port D output value (byte 0x40) whose bit 1 differs from the stored bit 1 raises sens_edge_stb for one cycle, in the cycle after the write. In that cycle sens_clk_lvl equals the written bit 1 and sens_data equals the written bit 4. Both hold their values until the next event.
- R7: A legal write to port D output value that keeps bit 1 unchanged raises no strobe and leaves sens_clk_lvl and sens_data unchanged.
- R8: Byte address bits [1:0] are ignored. The register index is req_addr[6:2].
- R9: A request whose byte enables are not all set (4'hF) gets rsp_err and read data zero. If it is a write, it changes no register and raises no event.
- R10: A request to an index of 23 or above (byte address 0x5C and up) gets rsp_err and read data zero, and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 7 | Byte address within the window |
| req_be | input | 4 | Byte enables; only 4'hF is legal |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response for the request of the previous cycle |
| rsp_err | output | 1 | Request was rejected |
| rsp_rdata | output | 32 | Read data, zero for writes and errors |
| nand_rdy | input | 1 | Flash ready line |
| nand_ale | output | 1 | Flash address-latch enable |
| nand_cle | output | 1 | Flash command-latch enable |
| nand_ce | output | 1 | Flash chip enable |
| sens_sdo | input | 1 | Sensor serial output |
| sens_edge_stb | output | 1 | One-cycle sensor clock edge event |
| sens_clk_lvl | output | 1 | Sensor clock level of the latest event |
| sens_data | output | 1 | Data bit of the latest event |

## Verification
Two things can land in the same cycle: the port D clock-edge detector and the access-legality check. A write with a partial byte enable that would flip bit 1 is what brings them together. It is judged correct only if the response carries an error, no strobe rises, and the held clock level and data stay as they were. The sensor serial line is also changed while port D writes are toggling the clock. A port D input-view read issued right after such a write must show the new stored value, masked, ORed with the live line.

// File: rtl/sbg_pkg.sv
package sbg_pkg;
  // word indices whose behaviour is special
  localparam int IX_A_OUT  = 'h00;
  localparam int IX_A_VIEW = 'h01;
  localparam int IX_A_EN   = 'h02;
  localparam int IX_D_OUT  = 'h10;
  localparam int IX_D_VIEW = 'h11;
  localparam int IX_D_EN   = 'h12;

  // bit positions
  localparam int B_A_RDY  = 7;
  localparam int B_A_ALE  = 6;
  localparam int B_A_CLE  = 5;
  localparam int B_A_CE   = 4;
  localparam int B_D_SCLK = 1;
  localparam int B_D_SDAT = 4;
  localparam int B_D_SDO  = 4;

  typedef struct packed {
    logic stb;
    logic lvl;
    logic dat;
  } sbg_evt_t;
endpackage

// File: rtl/sbg_rst_sync.sv
module sbg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/sbg_regfile.sv
module sbg_regfile #(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 23,
  parameter int IDX_W     = 5
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [DATA_W-1:0]                 wr_data,
  output logic [NUM_WORDS-1:0][DATA_W-1:0]  regs
);
  logic [NUM_WORDS-1:0] word_en;

  for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
    always_comb word_en[w] = wr_en && (wr_idx == IDX_W'(w));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          regs[w] <= '0;
      else if (word_en[w]) regs[w] <= wr_data;
    end
  end

  // R2: a legal write is visible at its index the next cycle
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> regs[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/sbg_rdmux.sv
module sbg_rdmux
  import sbg_pkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int NUM_WORDS = 23,
  parameter int IDX_W     = 5
) (
  input  logic [NUM_WORDS-1:0][DATA_W-1:0]  regs,
  input  logic [IDX_W-1:0]                  idx,
  input  logic                              nand_rdy,
  input  logic                              sens_sdo,
  output logic [DATA_W-1:0]                 rd_val
);
  logic [DATA_W-1:0] a_view, d_view;

  always_comb begin
    a_view = (regs[IX_A_OUT] & regs[IX_A_EN]) | (DATA_W'(nand_rdy) << B_A_RDY);
    d_view = (regs[IX_D_OUT] & regs[IX_D_EN]) | (DATA_W'(sens_sdo) << B_D_SDO);
    rd_val = '0;
    if (idx == IDX_W'(IX_A_VIEW))       rd_val = a_view;
    else if (idx == IDX_W'(IX_D_VIEW))  rd_val = d_view;
    else if (idx < IDX_W'(NUM_WORDS))   rd_val = regs[idx];
  end
endmodule

// File: rtl/sbg_sclk_evt.sv
module sbg_sclk_evt
  import sbg_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic              wr_sclk,
  input  logic              wr_sdat,
  input  logic              cur_sclk,
  output sbg_evt_t          evt
);
  logic     hit;
  sbg_evt_t evt_d, evt_q;

  always_comb begin
    hit   = wr_en && (wr_idx == IDX_W'(IX_D_OUT)) && (wr_sclk != cur_sclk);
    evt_d = evt_q;
    evt_d.stb = hit;
    if (hit) begin
      evt_d.lvl = wr_sclk;
      evt_d.dat = wr_sdat;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= evt_d;
  end

  assign evt = evt_q;

  // R7: a port D write that keeps the clock level makes no event
  a_r7_no_evt_same_level: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == IDX_W'(IX_D_OUT) && wr_sclk == cur_sclk) |=> !evt_q.stb);
endmodule

// File: rtl/sideband_gpio.sv
module sideband_gpio
  import sbg_pkg::*;
#(
  parameter  int DATA_W    = 32,
  parameter  int NUM_WORDS = 23,
  localparam int IDX_W     = $clog2(NUM_WORDS),
  localparam int ADDR_W    = IDX_W + 2,
  localparam int BE_W      = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [BE_W-1:0]   req_be,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic              nand_rdy,
  output logic              nand_ale,
  output logic              nand_cle,
  output logic              nand_ce,
  input  logic              sens_sdo,
  output logic              sens_edge_stb,
  output logic              sens_clk_lvl,
  output logic              sens_data
);
  logic                             rst_i_n;
  logic [IDX_W-1:0]                 idx;
  logic                             legal, wr_en;
  logic [DATA_W-1:0]                rd_val;
  logic [NUM_WORDS-1:0][DATA_W-1:0] regs;
  sbg_evt_t                         evt;
  logic                             vld_d, err_d, vld_q, err_q;
  logic [DATA_W-1:0]                dat_d, dat_q;
  logic                             unused_lowaddr;

  sbg_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_i_n));

  // decode: byte lane bits are not part of the index
  assign idx            = req_addr[ADDR_W-1:2];
  assign unused_lowaddr = ^req_addr[1:0];
  assign legal          = (idx < IDX_W'(NUM_WORDS)) && (&req_be);
  assign wr_en          = req_valid && req_write && legal;

  sbg_regfile #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .wr_idx(idx),
    .wr_data(req_wdata), .regs(regs));

  sbg_rdmux #(.DATA_W(DATA_W), .NUM_WORDS(NUM_WORDS), .IDX_W(IDX_W)) u_rd (
    .regs(regs), .idx(idx), .nand_rdy(nand_rdy), .sens_sdo(sens_sdo),
    .rd_val(rd_val));

  sbg_sclk_evt #(.IDX_W(IDX_W)) u_evt (
    .clk(clk), .rst_n(rst_i_n), .wr_en(wr_en), .wr_idx(idx),
    .wr_sclk(req_wdata[B_D_SCLK]), .wr_sdat(req_wdata[B_D_SDAT]),
    .cur_sclk(regs[IX_D_OUT][B_D_SCLK]), .evt(evt));

  // response next state
  always_comb begin
    vld_d = req_valid;
    err_d = req_valid && !legal;
    dat_d = (req_valid && !req_write && legal) ? rd_val : '0;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      vld_q <= 1'b0;
      err_q <= 1'b0;
      dat_q <= '0;
    end else begin
      vld_q <= vld_d;
      err_q <= err_d;
      dat_q <= dat_d;
    end
  end

  assign rsp_valid     = vld_q;
  assign rsp_err       = err_q;
  assign rsp_rdata     = dat_q;
  assign nand_ale      = regs[IX_A_OUT][B_A_ALE];
  assign nand_cle      = regs[IX_A_OUT][B_A_CLE];
  assign nand_ce       = regs[IX_A_OUT][B_A_CE];
  assign sens_edge_stb = evt.stb;
  assign sens_clk_lvl  = evt.lvl;
  assign sens_data     = evt.dat;

  // R2: one response per request, one cycle later
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_i_n)
    req_valid |=> rsp_valid);
  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_i_n)
    !req_valid |=> !rsp_valid);
  // R6: level and data only move with a strobe
  a_r6_level_held: assert property (@(posedge clk) disable iff (!rst_i_n)
    !sens_edge_stb |-> ($stable(sens_clk_lvl) && $stable(sens_data)));
  // R6: strobed level agrees with the stored port D clock bit
  a_r6_lvl_matches_store: assert property (@(posedge clk) disable iff (!rst_i_n)
    sens_edge_stb |-> sens_clk_lvl == regs[IX_D_OUT][B_D_SCLK]);
  // R9: a rejected request never produces an event
  a_r9_no_evt_on_err: assert property (@(posedge clk) disable iff (!rst_i_n)
    rsp_err |-> !sens_edge_stb);
  // R9/R10: a rejected write leaves storage untouched
  a_r9_err_keeps_regs: assert property (@(posedge clk) disable iff (!rst_i_n)
    (req_valid && req_write && !legal) |=> $stable(regs));
endmodule

// File: tb/sideband_gpio_test.sv
`timescale 1ns/1ps
module sideband_gpio_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [6:0]  req_addr;
  logic [3:0]  req_be;
  logic [31:0] req_wdata;
  logic        rsp_valid, rsp_err;
  logic [31:0] rsp_rdata;
  logic        nand_rdy, nand_ale, nand_cle, nand_ce;
  logic        sens_sdo, sens_edge_stb, sens_clk_lvl, sens_data;

  always #5 clk = ~clk;

  sideband_gpio uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_be(req_be), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .nand_rdy(nand_rdy), .nand_ale(nand_ale), .nand_cle(nand_cle), .nand_ce(nand_ce),
    .sens_sdo(sens_sdo), .sens_edge_stb(sens_edge_stb),
    .sens_clk_lvl(sens_clk_lvl), .sens_data(sens_data));

  int total = 0;
  int fails = 0;
  bit finished = 0;

  // reference model state
  int unsigned mdl[23];
  bit m_lvl = 0, m_dat = 0;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_pins(string tag, bit stb);
    chk({tag, " ale"}, nand_ale, mdl[0][6]);
    chk({tag, " cle"}, nand_cle, mdl[0][5]);
    chk({tag, " ce"},  nand_ce,  mdl[0][4]);
    chk({tag, " stb"}, sens_edge_stb, stb);
    chk({tag, " lvl"}, sens_clk_lvl, m_lvl);
    chk({tag, " dat"}, sens_data, m_dat);
  endtask

  // one request; model predicts, compared on the following cycle
  task automatic access(string tag, bit wr, logic [6:0] addr, logic [31:0] wd,
                        logic [3:0] be, bit rdy, bit sdo);
    int idx;
    bit ok, stb;
    logic [31:0] exp;
    idx = int'(addr >> 2);
    ok  = (idx < 23) && (be == 4'hF);
    exp = 32'h0;
    stb = 0;
    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = wd; req_be = be;
    nand_rdy = rdy; sens_sdo = sdo;
    if (ok && !wr) begin
      if (idx == 1)       exp = (mdl[0] & mdl[2]) | (32'(rdy) << 7);
      else if (idx == 17) exp = (mdl[16] & mdl[18]) | (32'(sdo) << 4);
      else                exp = mdl[idx];
    end
    if (ok && wr) begin
      if (idx == 16 && wd[1] != mdl[16][1]) begin
        stb = 1; m_lvl = wd[1]; m_dat = wd[4];
      end
      mdl[idx] = wd;
    end
    @(posedge clk);
    @(negedge clk);
    chk({tag, " rsp_valid"}, rsp_valid, 1);
    chk({tag, " rsp_err"}, rsp_err, !ok);
    chk({tag, " rdata"}, rsp_rdata, exp);
    check_pins(tag, stb);
    req_valid = 0;
  endtask

  task automatic idle(string tag);
    req_valid = 0;
    @(posedge clk);
    @(negedge clk);
    chk({tag, " idle rsp_valid"}, rsp_valid, 0);
    check_pins({tag, " idle"}, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 23; i++) mdl[i] = 0;
    rst_n = 0; req_valid = 0; req_write = 0; req_addr = '0; req_be = '0;
    req_wdata = '0; nand_rdy = 0; sens_sdo = 0;
    repeat (3) @(negedge clk);
    // R1: state held in reset
    chk("R1 rsp_valid in reset", rsp_valid, 0);
    check_pins("R1 reset", 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    idle("R1");
    for (int i = 0; i < 23; i++) access("R1 read zero", 0, 7'(i * 4), 0, 4'hF, 0, 0);

    // R4 ready line alone
    access("R4 a rdy", 0, 7'h04, 0, 4'hF, 1, 0);
    // R5 flash pins
    access("R5 set oe", 1, 7'h08, 32'h0000_00FF, 4'hF, 0, 0);
    access("R5 all pins", 1, 7'h00, 32'h0000_0070, 4'hF, 0, 0);
    access("R3 a view", 0, 7'h04, 0, 4'hF, 0, 0);
    access("R4 a view rdy", 0, 7'h04, 0, 4'hF, 1, 0);
    access("R5 ale only", 1, 7'h00, 32'h0000_0040, 4'hF, 0, 0);
    access("R5 cle only", 1, 7'h00, 32'hFFFF_FF20, 4'hF, 0, 0);
    access("R3 narrow oe", 1, 7'h08, 32'h0000_000F, 4'hF, 0, 0);
    access("R3 masked", 0, 7'h04, 0, 4'hF, 0, 0);
    access("R3 write view", 1, 7'h04, 32'hFFFF_FFFF, 4'hF, 0, 0);
    access("R3 view unchanged", 0, 7'h04, 0, 4'hF, 1, 0);

    // R2 plain storage
    access("R2 wr 5", 1, 7'h14, 32'hDEAD_BEEF, 4'hF, 0, 0);
    access("R2 rd 5", 0, 7'h14, 0, 4'hF, 0, 0);
    access("R2 wr 22", 1, 7'h58, 32'h1234_5678, 4'hF, 0, 0);
    access("R2 rd 22", 0, 7'h58, 0, 4'hF, 0, 0);
    idle("R2");
    // R8 low address bits
    access("R8 wr off3", 1, 7'h17, 32'hA5A5_0001, 4'hF, 0, 0);
    access("R8 rd off1", 0, 7'h15, 0, 4'hF, 0, 0);
    // R10 outside window
    access("R10 wr 0x5C", 1, 7'h5C, 32'hFFFF_FFFF, 4'hF, 0, 0);
    access("R10 rd 0x7C", 0, 7'h7C, 0, 4'hF, 0, 0);

    // R9 partial strobe toggling the clock bit: error, no event
    access("R9 bad be", 1, 7'h40, 32'h0000_0012, 4'h3, 0, 1);
    access("R9 rd d out", 0, 7'h40, 0, 4'hF, 0, 0);
    access("R9 bad be rd", 0, 7'h14, 0, 4'h7, 0, 0);

    // R6 / R7 sensor events
    access("R6 rise", 1, 7'h40, 32'h0000_0002, 4'hF, 0, 0);
    access("R7 same lvl", 1, 7'h40, 32'h0000_0012, 4'hF, 0, 0);
    idle("R6 hold");
    access("R6 fall d1", 1, 7'h40, 32'h0000_0010, 4'hF, 0, 1);
    for (int k = 0; k < 8; k++)
      access("R6 burst", 1, 7'h43, 32'((k[0] ? 0 : 2) | (k[1] ? 16 : 0)), 4'hF, 0, k[2]);
    access("R7 same lvl2", 1, 7'h40, 32'hFFFF_FFED, 4'hF, 0, 0);

    // R4 port D view with sensor line
    access("R4 d oe", 1, 7'h48, 32'h0000_00FF, 4'hF, 0, 0);
    access("R4 d view sdo1", 0, 7'h44, 0, 4'hF, 0, 1);
    access("R6 rise then read", 1, 7'h40, 32'h0000_0002, 4'hF, 0, 1);
    access("R4 d view sdo0", 0, 7'h44, 0, 4'hF, 0, 0);
    access("R4 d view sdo1b", 0, 7'h47, 0, 4'hF, 0, 1);
    idle("end");

    finished = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule